// File: doc/BRIEF.md
# Base Clock Source Divider

This block produces the base clock enable that drives the CPU and peripheral bus clocks. It picks its timing from one of two groups. The first is the PLL clock sent through a divider that can be set to 2, 3, 4 or 6. The second is a low-speed group of three sources: the sub clock as it arrives, the on-chip oscillator after a fixed /4 prescaler, and the main clock after a fixed /256 prescaler. Every clock is modelled as a one-cycle enable pulse on a single fast system clock. The output is therefore also an enable pulse, and the logic stays fully synchronous.

Software may change the divide code or the source selection at any time. One example is raising the PLL ratio after the main oscillator has failed, to guard against PLL overshoot. No change takes effect in the middle of an output period. A new divide code is taken at the end of the divider's current period. A new source selection is taken on a pulse of the source that is active at that moment. As a result, a ratio change never shortens a period below the old setting or the new one.

Top module: `base_clk_div`

## Requirements
- R1: With `src_sel`=0 and the PLL enable steady, the spacing between `base_en` pulses is N PLL enables, where `pll_div` encodes N as 00=/2, 01=/3, 10=/4, 11=/6.
- R2: While `rst_n` is low, `base_en` stays 0. After reset the block selects the PLL path with divide-by-6, so the first settled period is 6 PLL enables.
- R3: `src_sel`=0 selects the divided PLL clock and `src_sel`=1 selects the low-speed group. `base_en` pulses exactly one cycle after each pulse of the active source.
- R4: With `src_sel`=1 the low-speed code works as follows. 00 passes each sub clock enable straight through as a base pulse. 01 gives one pulse per 4 on-chip oscillator enables. 10 gives one pulse per 256 main clock enables, from an 8-bit free-running counter.
- R5: At divide-by-3 with a steady PLL enable, the base pulses are evenly spaced at exactly 3 PLL enables.
- R6: A change of `pll_div` takes effect only at the end of the divider's current period. The period in progress keeps the old ratio, and the next period uses the new one.
- R7: A change of `src_sel` or `low_sel` takes effect only on a pulse of the source active at that moment. Until that pulse, the old source keeps setting the timing.
- R8: Low-speed code 11 behaves like 00 and selects the sub clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | PLL clock enable pulse |
| sub_en | input | 1 | Sub clock enable pulse |
| oco_en | input | 1 | On-chip oscillator enable pulse |
| main_en | input | 1 | Main clock enable pulse |
| src_sel | input | 1 | 0 = divided PLL, 1 = low-speed group |
| pll_div | input | 2 | PLL divide code (00=/2, 01=/3, 10=/4, 11=/6) |
| low_sel | input | 2 | Low-speed source (00=sub, 01=osc/4, 10=main/256, 11=sub) |
| base_en | output | 1 | Base clock enable pulse |

## Verification
The bench builds the block with its default prescaler widths, 2 bits for the oscillator path and 8 bits for the main clock path. With these widths the full /256 wrap of the main clock counter takes only a few hundred cycles per period, so it can be measured exactly next to the four PLL ratios. The bench drives the PLL enable at several densities. At each density it measures the intervals between pulses around each mid-run change of ratio and source, which shows where a new setting is first applied.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
   localparam int unsigned BCD_MAX_RATIO = 6;
   localparam int unsigned BCD_CNT_W     = $clog2(BCD_MAX_RATIO);

   typedef enum logic [1:0] {DIV2 = 2'b00, DIV3 = 2'b01, DIV4 = 2'b10, DIV6 = 2'b11} div_code_t;
   typedef enum logic [1:0] {LS_SUB = 2'b00, LS_OCO = 2'b01, LS_MAIN = 2'b10, LS_ALT = 2'b11} low_sel_t;

   // last count value of a period (ratio - 1)
   function automatic logic [BCD_CNT_W-1:0] div_last(input div_code_t code);
      case (code)
         DIV2:    div_last = BCD_CNT_W'(1);
         DIV3:    div_last = BCD_CNT_W'(2);
         DIV4:    div_last = BCD_CNT_W'(3);
         default: div_last = BCD_CNT_W'(BCD_MAX_RATIO - 1);
      endcase
   endfunction
endpackage

// File: rtl/bcd_prescale.sv
`timescale 1ns/1ps
module bcd_prescale #(
   parameter int unsigned PRE_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_en,
   output logic out_en
);
   generate
      if (PRE_W > 16) begin : g_bad_width
         $error("bcd_prescale: PRE_W must be 16 or less");
      end
      if (PRE_W == 0) begin : g_pass
         assign out_en = in_en;
      end else begin : g_count
         logic [PRE_W-1:0] cnt_q;
         logic             pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= in_en && (&cnt_q);
               if (in_en) cnt_q <= cnt_q + 1'b1;
            end
         end
         assign out_en = pulse_q;
      end
   endgenerate
endmodule

// File: rtl/bcd_pll_div.sv
`timescale 1ns/1ps
module bcd_pll_div
   import bcd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pll_en,
   input  div_code_t div_code,
   output logic      div_pulse
);
   logic [BCD_CNT_W-1:0] cnt_q;
   div_code_t            code_q;
   logic                 pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         code_q  <= DIV6;
         pulse_q <= 1'b0;
      end else if (pll_en) begin
         if (cnt_q == div_last(code_q)) begin
            cnt_q   <= '0;
            code_q  <= div_code;
            pulse_q <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            pulse_q <= 1'b0;
         end
      end else begin
         pulse_q <= 1'b0;
      end
   end

   assign div_pulse = pulse_q;
endmodule

// File: rtl/bcd_src_mux.sv
`timescale 1ns/1ps
module bcd_src_mux
   import bcd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pll_pulse,
   input  logic     sub_pulse,
   input  logic     oco_pulse,
   input  logic     main_pulse,
   input  logic     src_sel,
   input  low_sel_t low_sel,
   output logic     act_src,
   output logic     act_pulse,
   output logic     base_en
);
   low_sel_t act_low_q;
   logic     act_src_q;
   logic     base_q;
   logic     low_pulse;

   always_comb begin
      case (act_low_q)
         LS_OCO:  low_pulse = oco_pulse;
         LS_MAIN: low_pulse = main_pulse;
         default: low_pulse = sub_pulse;
      endcase
   end

   assign act_pulse = act_src_q ? low_pulse : pll_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_src_q <= 1'b0;
         act_low_q <= LS_SUB;
         base_q    <= 1'b0;
      end else begin
         base_q <= act_pulse;
         if (act_pulse) begin
            act_src_q <= src_sel;
            act_low_q <= low_sel;
         end
      end
   end

   assign act_src = act_src_q;
   assign base_en = base_q;
endmodule

// File: rtl/base_clk_div.sv
`timescale 1ns/1ps
module base_clk_div
   import bcd_pkg::*;
#(
   parameter int unsigned OCO_PRE_W  = 2,
   parameter int unsigned MAIN_PRE_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pll_en,
   input  logic       sub_en,
   input  logic       oco_en,
   input  logic       main_en,
   input  logic       src_sel,
   input  logic [1:0] pll_div,
   input  logic [1:0] low_sel,
   output logic       base_en
);
   generate
      if (OCO_PRE_W == 0 || MAIN_PRE_W == 0) begin : g_bad_pre
         $error("base_clk_div: prescaler widths must be nonzero");
      end
   endgenerate

   logic div_pulse;
   logic oco_pulse;
   logic main_pulse;
   logic act_src;
   logic act_pulse;

   bcd_pll_div u_div (
      .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
      .div_code(div_code_t'(pll_div)), .div_pulse(div_pulse)
   );

   bcd_prescale #(.PRE_W(OCO_PRE_W)) u_oco_pre (
      .clk(clk), .rst_n(rst_n), .in_en(oco_en), .out_en(oco_pulse)
   );

   bcd_prescale #(.PRE_W(MAIN_PRE_W)) u_main_pre (
      .clk(clk), .rst_n(rst_n), .in_en(main_en), .out_en(main_pulse)
   );

   bcd_src_mux u_mux (
      .clk(clk), .rst_n(rst_n),
      .pll_pulse(div_pulse), .sub_pulse(sub_en),
      .oco_pulse(oco_pulse), .main_pulse(main_pulse),
      .src_sel(src_sel), .low_sel(low_sel_t'(low_sel)),
      .act_src(act_src), .act_pulse(act_pulse), .base_en(base_en)
   );
endmodule

// File: rtl/bcd_checker.sv
`timescale 1ns/1ps
module bcd_checker (
   input logic clk,
   input logic rst_n,
   input logic pll_en,
   input logic oco_en,
   input logic main_en,
   input logic div_pulse,
   input logic oco_pulse,
   input logic main_pulse,
   input logic act_src,
   input logic act_pulse,
   input logic base_en
);
   // R1
   div_from_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> $past(pll_en));
   // R4
   oco_from_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oco_pulse |-> $past(oco_en));
   // R4
   main_from_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      main_pulse |-> $past(main_en));
   // R3
   base_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_pulse |=> base_en);
   // R3
   base_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_pulse |=> !base_en);
   // R7
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_pulse |=> $stable(act_src));
   // R2
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!base_en);
      end
   end
endmodule

bind base_clk_div bcd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .oco_en(oco_en),
   .main_en(main_en), .div_pulse(div_pulse), .oco_pulse(oco_pulse),
   .main_pulse(main_pulse), .act_src(act_src), .act_pulse(act_pulse),
   .base_en(base_en)
);

// File: tb/base_clk_div_test.sv
`timescale 1ns/1ps
module base_clk_div_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pll_en = 1'b0, sub_en = 1'b0, oco_en = 1'b0, main_en = 1'b0;
   logic       src_sel = 1'b0;
   logic [1:0] pll_div = 2'b11;
   logic [1:0] low_sel = 2'b00;
   logic       base_en;

   int pll_gap = 1, sub_gap = 7, oco_gap = 3, main_gap = 1;
   int pc = 0, sc = 0, oc = 0, mc = 0;
   int cyc = 0, last_t = 0, last_iv = 0, pcnt = 0;
   int checks = 0, fails = 0;

   base_clk_div uut (
      .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .sub_en(sub_en),
      .oco_en(oco_en), .main_en(main_en), .src_sel(src_sel),
      .pll_div(pll_div), .low_sel(low_sel), .base_en(base_en)
   );

   always #2.5 clk = ~clk;

   // enable generators, driven away from the active edge
   always @(negedge clk) begin
      if (pc >= pll_gap - 1) begin pc = 0; pll_en <= 1'b1; end else begin pc++; pll_en <= 1'b0; end
      if (sc >= sub_gap - 1) begin sc = 0; sub_en <= 1'b1; end else begin sc++; sub_en <= 1'b0; end
      if (oc >= oco_gap - 1) begin oc = 0; oco_en <= 1'b1; end else begin oc++; oco_en <= 1'b0; end
      if (mc >= main_gap - 1) begin mc = 0; main_en <= 1'b1; end else begin mc++; main_en <= 1'b0; end
   end

   // pulse interval monitor
   always @(posedge clk) begin
      #1;
      cyc++;
      if (base_en) begin
         last_iv = cyc - last_t;
         last_t  = cyc;
         pcnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_iv(output int iv);
      int s = pcnt;
      while (pcnt == s) @(negedge clk);
      iv = last_iv;
   endtask

   task automatic skip(input int n);
      int iv;
      for (int i = 0; i < n; i++) next_iv(iv);
   endtask

   task automatic t_reset();
      int iv;
      repeat (5) @(negedge clk);
      chk(base_en == 1'b0, "R2 quiet in reset", base_en, 0);
      rst_n = 1'b1;
      skip(1);
      next_iv(iv);
      chk(iv == 6, "R2 default divide-by-6", iv, 6);
   endtask

   task automatic t_ratios(input int gap);
      int iv;
      int ratio [4] = '{2, 3, 4, 6};
      pll_gap = gap;
      for (int c = 0; c < 4; c++) begin
         pll_div = 2'(c);
         skip(3);
         next_iv(iv);
         chk(iv == ratio[c] * gap, "R1 divide ratio", iv, ratio[c] * gap);
      end
   endtask

   task automatic t_third();
      int iv;
      pll_gap = 1;
      pll_div = 2'b01;
      skip(3);
      for (int i = 0; i < 4; i++) begin
         next_iv(iv);
         chk(iv == 3, "R5 even divide-by-3", iv, 3);
      end
   endtask

   task automatic t_change();
      int iv;
      pll_gap = 1;
      pll_div = 2'b11;
      skip(3);
      pll_div = 2'b00;
      next_iv(iv);
      chk(iv == 6, "R6 old ratio completes", iv, 6);
      next_iv(iv);
      chk(iv == 2, "R6 new ratio applied", iv, 2);
      pll_div = 2'b11;
      next_iv(iv);
      chk(iv == 2, "R6 old ratio completes", iv, 2);
      next_iv(iv);
      chk(iv == 6, "R6 new ratio applied", iv, 6);
   endtask

   task automatic t_low();
      int iv;
      sub_gap = 7; oco_gap = 3; main_gap = 1;
      src_sel = 1'b1;
      low_sel = 2'b00;
      skip(3);
      next_iv(iv);
      chk(iv == 7, "R4 sub clock direct", iv, 7);
      chk(iv == 7, "R3 low-speed group selected", iv, 7);
      low_sel = 2'b01;
      skip(3);
      next_iv(iv);
      chk(iv == 12, "R4 oscillator /4", iv, 12);
      low_sel = 2'b10;
      skip(2);
      next_iv(iv);
      chk(iv == 256, "R4 main clock /256", iv, 256);
      low_sel = 2'b11;
      skip(3);
      next_iv(iv);
      chk(iv == 7, "R8 code 11 selects sub", iv, 7);
   endtask

   task automatic t_defer();
      int iv;
      sub_gap = 40; oco_gap = 1;
      src_sel = 1'b1;
      low_sel = 2'b00;
      skip(3);
      low_sel = 2'b01;
      next_iv(iv);
      chk(iv == 40, "R7 low_sel held until sub pulse", iv, 40);
      skip(2);
      next_iv(iv);
      chk(iv == 4, "R7 new low source active", iv, 4);
      low_sel = 2'b00;
      skip(3);
      pll_gap = 1;
      pll_div = 2'b00;
      src_sel = 1'b0;
      next_iv(iv);
      chk(iv == 40, "R7 src_sel held until sub pulse", iv, 40);
      skip(1);
      next_iv(iv);
      chk(iv == 2, "R3 PLL group selected", iv, 2);
   endtask

   initial begin
      t_reset();
      t_ratios(1);
      t_ratios(2);
      t_third();
      t_change();
      t_low();
      t_defer();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule